// File: doc/BRIEF.md
# Power-delivery port alert, receive queue and transmit retry controller

This block sits between the packet decoder and encoder of a power-delivery port and a host that accesses registers. Valid packets from the decoder are kept in a small circular queue. Each kept packet raises a receive alert and, unless it is itself an acknowledge, triggers an automatic acknowledge reply. The host reads the oldest packet through the read outputs. It frees that entry by clearing the receive alert bit.

For host transmissions, the block sends the message to the encoder and then waits a fixed window for a matching acknowledge. It resends up to a parameterised number of times. It ends with a success, failed or discarded alert. A 16-bit alert register and a mask register drive the interrupt line. While the not-ready input is high, all host writes are ignored.

The encoder is reached through a start/done handshake. The decoder delivers one event per cycle through a valid strobe with a kind code.

Top module: `pd_port_alert_ctrl`

## Requirements
- R1: Alert bits are set when their events occur, whatever the mask. The bit positions are: bit 0 receive-message, bit 1 hard-reset-received, bit 2 transmit-failed, bit 3 transmit-discarded, bit 4 transmit-success. The interrupt is high while any alert bit is also set in the mask. The mask resets to all ones and the alerts reset to zero.
- R2: A host clear removes only the bits it writes as ones. Once no alert bit remains, the interrupt is low.
- R3: A packet event is decoder kind 1, with the header in bits [15:0]. Such a packet, arriving while receive is enabled and the controller is idle, is kept if the queue is not full. Keeping it raises bit 0. The oldest kept packet is shown on the read outputs.
- R4: Header fields are: type in bits [4:0], message ID in [11:9], object count in [14:12]. An acknowledge has type 1 and count 0. A kept packet that is not an acknowledge causes one encoder start with header 0x0001 | (ID<<9). A kept acknowledge causes no reply.
- R5: The queue holds DEPTH packets in DEPTH+1 slots. A packet arriving when the queue is full is dropped without a reply and without raising bit 0.
- R6: A hard-reset event (decoder kind 2) while receive is enabled raises bit 1, even when the queue is full.
- R7: When the host clears bit 0 and the queue is not empty, the oldest entry is removed. Bit 0 stays set while entries remain.
- R8: A transmission starts over again up to MAX_RETRY extra times (4 attempts by default). Each attempt waits ACK_WAIT cycles after encoder done. An acknowledge whose ID matches the sent header raises bit 4.
- R9: A source-capabilities message (type 1 with a nonzero count) is sent only once.
- R10: A packet that is not the matching acknowledge, received during the wait window, ends the transmission and raises bit 3. That packet is not queued.
- R11: When every attempt times out, bit 2 is raised.
- R12: While the not-ready input is high, host clear, mask write and transmit request have no effect.
- R13: A transmit request made while receive is disabled raises bit 3 without any encoder start. Decoder events are ignored while receive is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| not_ready | input | 1 | Host writes are ignored while high |
| rx_en | input | 1 | Receive enable |
| rx_valid | input | 1 | Decoder event strobe |
| rx_kind | input | 2 | 1 packet, 2 hard reset, others errored |
| rx_hdr | input | 16 | Decoded header |
| rx_data | input | WORDS*WORD_W | Decoded data objects |
| phy_tx_start | output | 1 | One-cycle encoder start pulse |
| phy_tx_hdr | output | 16 | Header to encode |
| phy_tx_data | output | WORDS*WORD_W | Data objects to encode |
| phy_tx_done | input | 1 | Encoder finished pulse |
| host_tx_req | input | 1 | Transmit request |
| host_tx_hdr | input | 16 | Header to transmit |
| host_tx_data | input | WORDS*WORD_W | Data objects to transmit |
| host_clr | input | 1 | Alert clear strobe |
| host_clr_bits | input | 16 | Bits to clear |
| host_mask_wr | input | 1 | Mask write strobe |
| host_mask_bits | input | 16 | New mask |
| rd_hdr | output | 16 | Header of oldest queued packet |
| rd_data | output | WORDS*WORD_W | Data of oldest queued packet |
| alert | output | 16 | Alert status |
| alert_mask | output | 16 | Alert mask |
| irq | output | 1 | Interrupt, active high |

## Verification
Some properties are checked on every cycle by assertions:
- set events always land in the status register;
- the queue is never written when full and never popped when empty;
- the controller produces at most one outcome per cycle;
- every reply header is an acknowledge;
- a source-capabilities message never reaches a second attempt;
- the mask cannot change while the block is not ready.

Other behaviours need the bench's directed scenarios:
- the attempt counts;
- the exact acknowledge ID;
- the drop of a packet that arrives at a full queue;
- the alert that is kept while the queue drains;
- the choice between discarded and failed.

// File: rtl/pd_alert_pkg.sv
package pd_alert_pkg;
   localparam int HDR_W = 16;

   localparam logic [1:0] RXK_PKT  = 2'd1;
   localparam logic [1:0] RXK_HRST = 2'd2;

   localparam int AL_RX_MSG  = 0;
   localparam int AL_RX_HRST = 1;
   localparam int AL_TX_FAIL = 2;
   localparam int AL_TX_DISC = 3;
   localparam int AL_TX_OK   = 4;
   localparam int AL_USED    = 5;

   localparam logic [4:0] TYPE_ONE = 5'd1;

   function automatic logic [2:0] hdr_id(input logic [HDR_W-1:0] h);
      return h[11:9];
   endfunction

   function automatic logic is_ack(input logic [HDR_W-1:0] h);
      return (h[4:0] == TYPE_ONE) && (h[14:12] == 3'd0);
   endfunction

   function automatic logic is_srccap(input logic [HDR_W-1:0] h);
      return (h[4:0] == TYPE_ONE) && (h[14:12] != 3'd0);
   endfunction

   function automatic logic [HDR_W-1:0] ack_hdr(input logic [2:0] id);
      return {4'b0000, id, 4'b0000, TYPE_ONE};
   endfunction
endpackage

// File: rtl/pd_rx_ring.sv
module pd_rx_ring #(
   parameter int DEPTH  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty,
   output logic              one_left
);
   localparam int SLOTS = DEPTH + 1;
   localparam int PTR_W = $clog2(SLOTS);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

   initial begin
      assert (DEPTH >= 1) else $error("pd_rx_ring: DEPTH must be at least 1");
   end

   logic [DATA_W-1:0] mem [SLOTS];
   logic [PTR_W-1:0]  head, tail, head_inc, tail_inc;

   if (SLOTS == (1 << PTR_W)) begin : g_pow2
      assign head_inc = head + 1'b1;
      assign tail_inc = tail + 1'b1;
   end else begin : g_wrap
      assign head_inc = (head == LAST) ? '0 : head + 1'b1;
      assign tail_inc = (tail == LAST) ? '0 : tail + 1'b1;
   end

   assign full     = (head_inc == tail);
   assign empty    = (head == tail);
   assign one_left = (tail_inc == head);
   assign rd_data  = mem[tail];

   always_ff @(posedge clk) begin
      if (push) mem[head] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
      end else begin
         if (push) head <= head_inc;
         if (pop)  tail <= tail_inc;
      end
   end

   a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/pd_alert_reg.sv
module pd_alert_reg #(
   parameter int ALERT_W = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ALERT_W-1:0] set,
   input  logic [ALERT_W-1:0] clr,
   input  logic               mask_wr,
   input  logic [ALERT_W-1:0] mask_in,
   output logic [ALERT_W-1:0] status,
   output logic [ALERT_W-1:0] mask,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '1;
      end else begin
         status <= (status & ~clr) | set;
         if (mask_wr) mask <= mask_in;
      end
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |(status & mask);
      end
   end else begin : g_irq_comb
      assign irq = |(status & mask);
      a_r2_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (status == '0) |-> !irq);
   end

   a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((status & $past(set)) == $past(set)));
endmodule

// File: rtl/pd_tx_ctrl.sv
module pd_tx_ctrl
   import pd_alert_pkg::*;
#(
   parameter int PAY_W     = 224,
   parameter int MAX_RETRY = 3,
   parameter int ACK_WAIT  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             rx_valid,
   input  logic [1:0]       rx_kind,
   input  logic [HDR_W-1:0] rx_hdr,
   input  logic             buf_full,
   input  logic             tx_req,
   input  logic [HDR_W-1:0] tx_hdr,
   input  logic [PAY_W-1:0] tx_data,
   input  logic             phy_done,
   output logic             push,
   output logic             phy_start,
   output logic [HDR_W-1:0] phy_hdr,
   output logic [PAY_W-1:0] phy_data,
   output logic             ev_rx_msg,
   output logic             ev_hrst,
   output logic             ev_fail,
   output logic             ev_disc,
   output logic             ev_ok
);
   localparam int AT_W = $clog2(MAX_RETRY + 2);
   localparam int WC_W = $clog2(ACK_WAIT + 1);
   localparam logic [AT_W-1:0] AT_MAX  = AT_W'(MAX_RETRY);
   localparam logic [WC_W-1:0] WC_LAST = WC_W'(ACK_WAIT - 1);

   initial begin
      assert (ACK_WAIT >= 2) else $error("pd_tx_ctrl: ACK_WAIT must be at least 2");
      assert (MAX_RETRY >= 0) else $error("pd_tx_ctrl: MAX_RETRY must not be negative");
   end

   typedef enum logic [1:0] {S_IDLE, S_REPLY, S_SEND, S_WAIT} state_e;

   state_e           state;
   logic             pend;
   logic [HDR_W-1:0] pend_hdr;
   logic [PAY_W-1:0] pend_data;
   logic [AT_W-1:0]  attempt;
   logic [WC_W-1:0]  wcnt;
   logic             start_q;
   logic [HDR_W-1:0] out_hdr;
   logic [PAY_W-1:0] out_data;

   logic rx_pkt, need_ack, launch, drop_req, wait_pkt, match, timeout, last_try;

   always_comb begin
      rx_pkt    = rx_valid && rx_en && (rx_kind == RXK_PKT);
      ev_hrst   = rx_valid && rx_en && (rx_kind == RXK_HRST);
      push      = (state == S_IDLE) && rx_pkt && !buf_full;
      ev_rx_msg = push;
      need_ack  = push && !is_ack(rx_hdr);
      launch    = (state == S_IDLE) && !rx_pkt && pend && rx_en;
      drop_req  = (state == S_IDLE) && pend && !rx_en;
      wait_pkt  = (state == S_WAIT) && rx_pkt;
      match     = is_ack(rx_hdr) && (hdr_id(rx_hdr) == hdr_id(out_hdr));
      timeout   = (state == S_WAIT) && !rx_pkt && (wcnt == WC_LAST);
      last_try  = is_srccap(out_hdr) ? (attempt == '0) : (attempt == AT_MAX);
      ev_ok     = wait_pkt && match;
      ev_disc   = (wait_pkt && !match) || drop_req;
      ev_fail   = timeout && last_try;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         pend      <= 1'b0;
         pend_hdr  <= '0;
         pend_data <= '0;
         attempt   <= '0;
         wcnt      <= '0;
         start_q   <= 1'b0;
         out_hdr   <= '0;
         out_data  <= '0;
      end else begin
         start_q <= 1'b0;
         if (tx_req) begin
            pend      <= 1'b1;
            pend_hdr  <= tx_hdr;
            pend_data <= tx_data;
         end else if (launch || drop_req) begin
            pend <= 1'b0;
         end
         case (state)
            S_IDLE: begin
               if (need_ack) begin
                  state    <= S_REPLY;
                  start_q  <= 1'b1;
                  out_hdr  <= ack_hdr(hdr_id(rx_hdr));
                  out_data <= '0;
               end else if (launch) begin
                  state    <= S_SEND;
                  start_q  <= 1'b1;
                  attempt  <= '0;
                  out_hdr  <= pend_hdr;
                  out_data <= pend_data;
               end
            end
            S_REPLY: if (phy_done) state <= S_IDLE;
            S_SEND: begin
               if (phy_done) begin
                  state <= S_WAIT;
                  wcnt  <= '0;
               end
            end
            S_WAIT: begin
               wcnt <= wcnt + 1'b1;
               if (wait_pkt) begin
                  state <= S_IDLE;
               end else if (timeout) begin
                  if (last_try) begin
                     state <= S_IDLE;
                  end else begin
                     attempt <= attempt + 1'b1;
                     state   <= S_SEND;
                     start_q <= 1'b1;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign phy_start = start_q;
   assign phy_hdr   = out_hdr;
   assign phy_data  = out_data;

   a_r4_reply_is_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && state == S_REPLY) |-> is_ack(out_hdr));
   a_r9_srccap_once: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT && is_srccap(out_hdr)) |-> (attempt == '0));
   a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_ok, ev_disc, ev_fail}));
   a_r13_no_launch_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && !rx_en) |=> !start_q);
endmodule

// File: rtl/pd_port_alert_ctrl.sv
module pd_port_alert_ctrl
   import pd_alert_pkg::*;
#(
   parameter int DEPTH     = 2,
   parameter int WORDS     = 7,
   parameter int WORD_W    = 32,
   parameter int MAX_RETRY = 3,
   parameter int ACK_WAIT  = 16,
   parameter int ALERT_W   = 16,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    not_ready,
   input  logic                    rx_en,
   input  logic                    rx_valid,
   input  logic [1:0]              rx_kind,
   input  logic [15:0]             rx_hdr,
   input  logic [WORDS*WORD_W-1:0] rx_data,
   output logic                    phy_tx_start,
   output logic [15:0]             phy_tx_hdr,
   output logic [WORDS*WORD_W-1:0] phy_tx_data,
   input  logic                    phy_tx_done,
   input  logic                    host_tx_req,
   input  logic [15:0]             host_tx_hdr,
   input  logic [WORDS*WORD_W-1:0] host_tx_data,
   input  logic                    host_clr,
   input  logic [ALERT_W-1:0]      host_clr_bits,
   input  logic                    host_mask_wr,
   input  logic [ALERT_W-1:0]      host_mask_bits,
   output logic [15:0]             rd_hdr,
   output logic [WORDS*WORD_W-1:0] rd_data,
   output logic [ALERT_W-1:0]      alert,
   output logic [ALERT_W-1:0]      alert_mask,
   output logic                    irq
);
   localparam int PAY_W   = WORDS * WORD_W;
   localparam int ENTRY_W = HDR_W + PAY_W;
   localparam logic [ALERT_W-1:0] RX_BIT = ALERT_W'(1) << AL_RX_MSG;

   initial begin
      assert (ALERT_W >= AL_USED) else $error("pd_port_alert_ctrl: ALERT_W too small");
      assert (WORDS >= 1 && WORD_W >= 1) else $error("pd_port_alert_ctrl: bad payload size");
   end

   logic               push, pop, full, empty, one_left, keep_rx;
   logic               ev_rx_msg, ev_hrst, ev_fail, ev_disc, ev_ok;
   logic               wr_ok;
   logic [ENTRY_W-1:0] head_entry;
   logic [ALERT_W-1:0] set_vec, clr_vec;

   assign wr_ok = !not_ready;

   pd_tx_ctrl #(.PAY_W(PAY_W), .MAX_RETRY(MAX_RETRY), .ACK_WAIT(ACK_WAIT)) u_tx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
      .rx_kind(rx_kind), .rx_hdr(rx_hdr), .buf_full(full),
      .tx_req(host_tx_req && wr_ok), .tx_hdr(host_tx_hdr), .tx_data(host_tx_data),
      .phy_done(phy_tx_done), .push(push), .phy_start(phy_tx_start),
      .phy_hdr(phy_tx_hdr), .phy_data(phy_tx_data),
      .ev_rx_msg(ev_rx_msg), .ev_hrst(ev_hrst), .ev_fail(ev_fail),
      .ev_disc(ev_disc), .ev_ok(ev_ok)
   );

   pd_rx_ring #(.DEPTH(DEPTH), .DATA_W(ENTRY_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data({rx_hdr, rx_data}),
      .pop(pop), .rd_data(head_entry), .full(full), .empty(empty),
      .one_left(one_left)
   );

   assign rd_hdr  = head_entry[ENTRY_W-1 -: HDR_W];
   assign rd_data = head_entry[PAY_W-1:0];

   always_comb begin
      pop     = host_clr && wr_ok && host_clr_bits[AL_RX_MSG] && !empty;
      keep_rx = pop && (!one_left || push);
      clr_vec = (host_clr && wr_ok) ? (host_clr_bits & ~(keep_rx ? RX_BIT : '0)) : '0;
      set_vec = '0;
      set_vec[AL_RX_MSG]  = ev_rx_msg;
      set_vec[AL_RX_HRST] = ev_hrst;
      set_vec[AL_TX_FAIL] = ev_fail;
      set_vec[AL_TX_DISC] = ev_disc;
      set_vec[AL_TX_OK]   = ev_ok;
   end

   pd_alert_reg #(.ALERT_W(ALERT_W), .IRQ_REG(IRQ_REG)) u_alert (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec),
      .mask_wr(host_mask_wr && wr_ok), .mask_in(host_mask_bits),
      .status(alert), .mask(alert_mask), .irq(irq)
   );

   a_r12_lock_mask: assert property (@(posedge clk) disable iff (!rst_n)
      not_ready |=> (alert_mask == $past(alert_mask)));
   a_r7_rx_bit_backed: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !pop) |=> alert[AL_RX_MSG]);
endmodule

// File: tb/test_pd_port_alert_ctrl.sv
module test_pd_port_alert_ctrl;
   localparam int PW = 7 * 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic not_ready = 1'b0, rx_en = 1'b1, rx_valid = 1'b0;
   logic [1:0] rx_kind = 2'd0;
   logic [15:0] rx_hdr = '0, host_tx_hdr = '0;
   logic [PW-1:0] rx_data = '0, host_tx_data = '0;
   logic phy_tx_start, phy_tx_done = 1'b0, host_tx_req = 1'b0;
   logic [15:0] phy_tx_hdr, rd_hdr, alert, alert_mask;
   logic [PW-1:0] phy_tx_data, rd_data;
   logic host_clr = 1'b0, host_mask_wr = 1'b0, irq;
   logic [15:0] host_clr_bits = '0, host_mask_bits = '0;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pd_port_alert_ctrl i_pd_port_alert_ctrl (
      .clk(clk), .rst_n(rst_n), .not_ready(not_ready), .rx_en(rx_en),
      .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_hdr(rx_hdr), .rx_data(rx_data),
      .phy_tx_start(phy_tx_start), .phy_tx_hdr(phy_tx_hdr), .phy_tx_data(phy_tx_data),
      .phy_tx_done(phy_tx_done), .host_tx_req(host_tx_req), .host_tx_hdr(host_tx_hdr),
      .host_tx_data(host_tx_data), .host_clr(host_clr), .host_clr_bits(host_clr_bits),
      .host_mask_wr(host_mask_wr), .host_mask_bits(host_mask_bits),
      .rd_hdr(rd_hdr), .rd_data(rd_data), .alert(alert), .alert_mask(alert_mask), .irq(irq)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send_rx(input logic [1:0] kind, input logic [15:0] hdr, input logic [31:0] w0);
      rx_valid = 1'b1; rx_kind = kind; rx_hdr = hdr;
      rx_data = '0; rx_data[31:0] = w0;
      tick();
      rx_valid = 1'b0; rx_kind = 2'd0;
   endtask

   task automatic clear(input logic [15:0] bits);
      host_clr = 1'b1; host_clr_bits = bits;
      tick();
      host_clr = 1'b0;
   endtask

   task automatic tx_req(input logic [15:0] hdr);
      host_tx_req = 1'b1; host_tx_hdr = hdr;
      host_tx_data = '0; host_tx_data[31:0] = 32'hC0DE_0001;
      tick();
      host_tx_req = 1'b0;
   endtask

   // waits for an encoder start, returns header, finishes it with done
   task automatic serve(output bit seen, output logic [15:0] hdr);
      seen = 1'b0; hdr = '0;
      for (int i = 0; i < 60 && !seen; i++) begin
         if (phy_tx_start) begin
            seen = 1'b1; hdr = phy_tx_hdr;
            phy_tx_done = 1'b1;
            tick();
            phy_tx_done = 1'b0;
         end else begin
            tick();
         end
      end
   endtask

   task automatic quiet(input int n, output bit started);
      started = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (phy_tx_start) started = 1'b1;
         tick();
      end
   endtask

   task automatic count_attempts(input int alert_bit, output int n);
      n = 0;
      for (int i = 0; i < 400; i++) begin
         if (alert[alert_bit]) break;
         if (phy_tx_start) begin
            n++;
            phy_tx_done = 1'b1;
            tick();
            phy_tx_done = 1'b0;
         end else begin
            tick();
         end
      end
   endtask

   task automatic t_reset();
      check(alert == 16'h0, "R1 reset alert", alert, 0);
      check(alert_mask == 16'hFFFF, "R1 reset mask", alert_mask, 16'hFFFF);
      check(irq == 1'b0, "R1 reset irq", irq, 0);
   endtask

   task automatic t_not_ready();
      bit st;
      not_ready = 1'b1;
      host_mask_wr = 1'b1; host_mask_bits = 16'h0000;
      tick();
      host_mask_wr = 1'b0;
      tx_req(16'h0803);
      quiet(10, st);
      check(alert_mask == 16'hFFFF, "R12 mask write ignored", alert_mask, 16'hFFFF);
      check(st == 1'b0, "R12 tx request ignored", st, 0);
      not_ready = 1'b0;
      quiet(5, st);
      check(st == 1'b0 && alert == 16'h0, "R12 nothing queued", alert, 0);
   endtask

   task automatic t_rx_reply();
      bit seen; logic [15:0] h;
      send_rx(2'd1, 16'h1A03, 32'h1234_5678);
      check(alert[0] == 1'b1, "R3 rx alert", alert, 1);
      check(irq == 1'b1, "R1 irq with mask", irq, 1);
      check(rd_hdr == 16'h1A03, "R3 read header", rd_hdr, 16'h1A03);
      check(rd_data[31:0] == 32'h1234_5678, "R3 read data", rd_data[31:0], 32'h1234_5678);
      serve(seen, h);
      check(seen && h == 16'h0A01, "R4 ack header", h, 16'h0A01);
   endtask

   task automatic t_mask();
      host_mask_wr = 1'b1; host_mask_bits = 16'h0000;
      tick();
      host_mask_wr = 1'b0;
      check(irq == 1'b0 && alert[0], "R1 masked irq low", irq, 0);
      host_mask_wr = 1'b1; host_mask_bits = 16'hFFFF;
      tick();
      host_mask_wr = 1'b0;
      check(irq == 1'b1, "R1 unmasked irq high", irq, 1);
   endtask

   task automatic t_ack_no_reply();
      bit st;
      send_rx(2'd1, 16'h0401, 32'h0);
      quiet(10, st);
      check(st == 1'b0, "R4 no reply to ack", st, 0);
   endtask

   task automatic t_full_and_pop();
      bit st;
      send_rx(2'd1, 16'h1C03, 32'h0);
      quiet(10, st);
      check(st == 1'b0, "R5 no reply when full", st, 0);
      check(rd_hdr == 16'h1A03, "R7 oldest first", rd_hdr, 16'h1A03);
      clear(16'h0001);
      check(alert[0] == 1'b1, "R7 alert kept while non-empty", alert[0], 1);
      check(rd_hdr == 16'h0401, "R7 tail advanced", rd_hdr, 16'h0401);
      clear(16'h0001);
      check(alert[0] == 1'b0, "R5 dropped packet not queued", alert[0], 0);
   endtask

   task automatic t_hard_reset();
      bit st;
      send_rx(2'd1, 16'h0201, 32'h0);
      send_rx(2'd1, 16'h0401, 32'h0);
      send_rx(2'd2, 16'h0000, 32'h0);
      quiet(3, st);
      check(alert == 16'h0003, "R6 hard reset with full queue", alert, 16'h0003);
      clear(16'hFFFF);
      check(alert == 16'h0001, "R2 W1C keeps rx bit", alert, 16'h0001);
      clear(16'hFFFF);
      check(alert == 16'h0000 && irq == 1'b0, "R2 irq low when clear", irq, 0);
   endtask

   task automatic t_tx_first_try();
      bit seen; logic [15:0] h;
      tx_req(16'h0803);
      serve(seen, h);
      check(seen && h == 16'h0803, "R8 sent header", h, 16'h0803);
      send_rx(2'd1, 16'h0801, 32'h0);
      tick();
      check(alert == 16'h0010, "R8 success alert, ack not queued", alert, 16'h0010);
      clear(16'hFFFF);
   endtask

   task automatic t_tx_third_try();
      bit seen; logic [15:0] h; int n = 0;
      tx_req(16'h0603);
      for (int i = 0; i < 3; i++) begin
         serve(seen, h);
         if (seen) n++;
      end
      send_rx(2'd1, 16'h0601, 32'h0);
      tick();
      check(n == 3, "R8 attempts before ack", n, 3);
      check(alert == 16'h0010, "R8 success on third try", alert, 16'h0010);
      clear(16'hFFFF);
   endtask

   task automatic t_tx_fail();
      int n;
      tx_req(16'h0403);
      count_attempts(2, n);
      check(n == 4, "R11 four attempts", n, 4);
      check(alert == 16'h0004, "R11 failed alert", alert, 16'h0004);
      clear(16'hFFFF);
   endtask

   task automatic t_srccap();
      int n;
      tx_req(16'h2201);
      count_attempts(2, n);
      check(n == 1, "R9 single attempt", n, 1);
      check(alert == 16'h0004, "R9 failed alert", alert, 16'h0004);
      clear(16'hFFFF);
   endtask

   task automatic t_discard();
      bit seen; logic [15:0] h; bit st;
      tx_req(16'h0803);
      serve(seen, h);
      send_rx(2'd1, 16'h0A01, 32'h0);
      quiet(2, st);
      check(alert == 16'h0008, "R10 wrong id discards", alert, 16'h0008);
      clear(16'hFFFF);
      tx_req(16'h0803);
      serve(seen, h);
      send_rx(2'd1, 16'h0A03, 32'h0);
      quiet(40, st);
      check(alert == 16'h0008, "R10 other packet discards, not queued", alert, 16'h0008);
      check(st == 1'b0, "R10 no retry after discard", st, 0);
      clear(16'hFFFF);
   endtask

   task automatic t_rx_off();
      bit st;
      rx_en = 1'b0;
      tx_req(16'h0803);
      quiet(4, st);
      check(st == 1'b0, "R13 no start while rx off", st, 0);
      check(alert == 16'h0008, "R13 discard alert", alert, 16'h0008);
      clear(16'hFFFF);
      send_rx(2'd1, 16'h1A03, 32'h0);
      quiet(4, st);
      check(alert == 16'h0000 && !st, "R13 rx ignored while off", alert, 0);
      rx_en = 1'b1;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_not_ready();
      t_rx_reply();
      t_mask();
      t_ack_no_reply();
      t_full_and_pop();
      t_hard_reset();
      t_tx_first_try();
      t_tx_third_try();
      t_tx_fail();
      t_srccap();
      t_discard();
      t_rx_off();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule